// File: doc/BRIEF.md
# Double-Rate Half-Width Memory Bridge

This block lets a processor that works in 32-bit words talk to a memory whose data port is only 16 bits wide. The bridge runs on a clock at twice the processor rate. Every processor cycle therefore holds two bridge cycles, called phase 0 and phase 1. A processor word address A maps to two memory locations. The even location 2A holds the upper half of the word and the odd location 2A+1 holds the lower half.

The processor presents a request in phase 0 and holds it for the whole processor cycle. The bridge acts on it at once. In phase 0 it issues the access to the even location, and in phase 1 it issues the access to the odd location from a copy it took at the end of phase 0. A write sends the two halves in turn. A read puts the two returned halves back together and hands the 32-bit word back one processor cycle later. The word then stays steady for a full processor cycle. No request ever stalls.

The memory is a plain synchronous single-port RAM. Its read data appears in the bridge cycle after the access. The bridge drives its memory-side outputs straight from the request inputs in phase 0 and from its registers in phase 1.

Top module: `split_mem_bridge`

## Requirements
- R1: While reset is held, `phase` is 0 and `rsp_valid` is 0. With no request present, no memory access is issued.
- R2: `phase` toggles on every bridge clock edge after reset. Phase 0 marks the first half of a processor cycle.
- R3: A request present in phase 0 gives `mem_en`=1 in both halves of that processor cycle. `mem_addr` is {A,0} in phase 0 and {A,1} in phase 1, where A is `req_addr`.
- R4: A write request (`req_write`=1) gives `mem_we`=1 in both phases. `mem_wdata` carries `req_wdata[31:16]` in phase 0 and `req_wdata[15:0]` in phase 1.
- R5: A read request gives `mem_we`=0 in both phases. It returns `rsp_rdata` = {memory[2A], memory[2A+1]}, with the even location in bits 31:16.
- R6: A read issued in the phase 0 bridge cycle c makes `rsp_valid`=1 with its data visible first in bridge cycle c+3. `rsp_valid` and `rsp_rdata` then hold unchanged through cycle c+4. Both change only at the edge that ends a phase 0 cycle.
- R7: If `req_valid` is 0 in phase 0, no memory access is issued in either phase of that processor cycle, and no response follows for that slot.
- R8: Changes to the request inputs during phase 1 do not affect the phase 1 access or the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock, twice the processor rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | output | 1 | Current half of the processor cycle (0 = first) |
| req_valid | input | 1 | Request present, sampled in phase 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Processor word address |
| req_wdata | input | 2*NW | Write word |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 2*NW | Read word, upper half from the even location |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW+1 | Memory half-word address |
| mem_wdata | output | NW | Memory write data |
| mem_rdata | input | NW | Memory read data, one bridge cycle after the access |

## Verification
The memory-side outputs are due in the same bridge cycle as the request for phase 0 and in the next bridge cycle for phase 1. The bench checks them one settling delay after the falling edge of each of those cycles. A read response is due three bridge cycles after the phase 0 cycle that carried the request. Each scoreboard entry records its due cycle from a free-running edge counter, and the monitor rejects a response that arrives in any other cycle. On the following bridge cycle the monitor checks that the response has not moved.

// File: rtl/split_mem_bridge.sv
module split_mem_bridge #(
  parameter int AW = 8,
  parameter int NW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            phase,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [2*NW-1:0] req_wdata,
  output logic            rsp_valid,
  output logic [2*NW-1:0] rsp_rdata,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW:0]     mem_addr,
  output logic [NW-1:0]   mem_wdata,
  input  logic [NW-1:0]   mem_rdata
);
  localparam int WW = 2 * NW;

  logic          act_q, we_q, rd_pend;
  logic [AW-1:0] addr_q;
  logic [NW-1:0] lo_q, hi_q;

  assign mem_en    = phase ? act_q : req_valid;
  assign mem_we    = mem_en & (phase ? we_q : req_write);
  assign mem_addr  = phase ? {addr_q, 1'b1} : {req_addr, 1'b0};
  assign mem_wdata = phase ? lo_q : req_wdata[WW-1:NW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      act_q     <= 1'b0;
      we_q      <= 1'b0;
      addr_q    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      rd_pend   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      phase <= ~phase;
      if (!phase) begin
        act_q     <= req_valid;
        we_q      <= req_write;
        addr_q    <= req_addr;
        lo_q      <= req_wdata[NW-1:0];
        rsp_valid <= rd_pend;
        if (rd_pend) rsp_rdata <= {hi_q, mem_rdata};
      end else begin
        rd_pend <= act_q & ~we_q;
        if (act_q & ~we_q) hi_q <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/split_mem_bridge_chk.sv
module split_mem_bridge_chk #(
  parameter int AW = 8,
  parameter int NW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            phase,
  input logic            req_valid,
  input logic            rsp_valid,
  input logic [2*NW-1:0] rsp_rdata,
  input logic            mem_en,
  input logic            mem_we,
  input logic [AW:0]     mem_addr
);
  p_phase_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase != $past(phase));

  p_idle_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && !req_valid) |=> !mem_en);

  p_half_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_addr[0] == phase);

  p_addr_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && mem_en) |=> mem_en && mem_addr[AW:1] == $past(mem_addr[AW:1]));

  p_we_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && mem_en) |=> mem_we == $past(mem_we));

  p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |-> $stable(rsp_rdata) && $stable(rsp_valid));
endmodule

bind split_mem_bridge split_mem_bridge_chk #(.AW(AW), .NW(NW)) chk_i (
  .clk(clk), .rst_n(rst_n), .phase(phase), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/split_mem_bridge_tb_top.sv
module split_mem_bridge_tb_top;
  localparam int AW = 8;
  localparam int NW = 16;
  localparam int WW = 2 * NW;
  localparam int MD = 2 ** (AW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase, req_valid, req_write, rsp_valid, mem_en, mem_we;
  logic [AW-1:0] req_addr;
  logic [WW-1:0] req_wdata, rsp_rdata;
  logic [AW:0]   mem_addr;
  logic [NW-1:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  split_mem_bridge #(.AW(AW), .NW(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .phase(phase), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  logic [NW-1:0] ram [MD];
  logic [NW-1:0] shadow [MD];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
  end

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [WW-1:0] exp_q [$];
  int due_q [$];
  logic [WW-1:0] held;

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (phase) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected response", rsp_rdata, '0);
        else begin
          chk(cyc == due_q[0], "R6 response cycle", WW'(cyc), WW'(due_q[0]));
          chk(rsp_rdata == exp_q[0], "R5 read word", rsp_rdata, exp_q[0]);
          void'(exp_q.pop_front());
          void'(due_q.pop_front());
        end
        held = rsp_rdata;
      end else begin
        chk(rsp_rdata == held, "R6 response hold", rsp_rdata, held);
      end
    end
  end

  task automatic slot(input bit v, input bit w, input logic [AW-1:0] a, input logic [WW-1:0] d);
    @(negedge clk);
    while (phase != 1'b0) @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    if (v && w) begin
      shadow[{a, 1'b0}] = d[WW-1:NW];
      shadow[{a, 1'b1}] = d[NW-1:0];
    end
    if (v && !w) begin
      exp_q.push_back({shadow[{a, 1'b0}], shadow[{a, 1'b1}]});
      due_q.push_back(cyc + 3);
    end
    #1;
    chk(mem_en == v, "R7/R3 phase0 enable", WW'(mem_en), WW'(v));
    if (v) begin
      chk(mem_addr == {a, 1'b0}, "R3 phase0 address", WW'(mem_addr), WW'({a, 1'b0}));
      chk(mem_we == w, "R4/R5 phase0 write enable", WW'(mem_we), WW'(w));
      if (w) chk(mem_wdata == d[WW-1:NW], "R4 upper half", WW'(mem_wdata), WW'(d[WW-1:NW]));
    end
    @(negedge clk);
    req_valid = ~v; req_write = ~w; req_addr = ~a; req_wdata = ~d;
    #1;
    chk(phase == 1'b1, "R2 phase", WW'(phase), 1);
    chk(mem_en == v, "R7/R8 phase1 enable", WW'(mem_en), WW'(v));
    if (v) begin
      chk(mem_addr == {a, 1'b1}, "R3/R8 phase1 address", WW'(mem_addr), WW'({a, 1'b1}));
      chk(mem_we == w, "R4/R5 phase1 write enable", WW'(mem_we), WW'(w));
      if (w) chk(mem_wdata == d[NW-1:0], "R4/R8 lower half", WW'(mem_wdata), WW'(d[NW-1:0]));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    for (int i = 0; i < MD; i++) begin
      ram[i] = NW'(i * 16'h0107) ^ 16'h5A3C;
      shadow[i] = NW'(i * 16'h0107) ^ 16'h5A3C;
    end
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(phase == 1'b0, "R1 reset phase", WW'(phase), 0);
    chk(rsp_valid == 1'b0, "R1 reset response", WW'(rsp_valid), 0);
    chk(mem_en == 1'b0, "R1 reset access", WW'(mem_en), 0);
    @(negedge clk) rst_n = 1'b1;

    slot(1, 1, 8'd3, 32'hDEAD_BEEF);
    slot(1, 0, 8'd3, '0);
    slot(1, 0, 8'd0, '0);
    slot(0, 0, 8'd0, '0);
    slot(1, 0, 8'd3, '0);
    slot(1, 1, 8'd3, 32'h1234_5678);
    slot(1, 0, 8'd3, '0);
    slot(1, 1, 8'd255, 32'hA5A5_0F0F);
    slot(0, 1, 8'd255, 32'hFFFF_FFFF);
    slot(1, 0, 8'd255, '0);
    slot(1, 0, 8'd128, '0);
    lcg = 32'h1357_9BDF;
    for (int k = 0; k < 60; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      slot(lcg[31:30] != 2'b00, lcg[29], AW'(lcg[15:8] & 8'h0F), {lcg[23:8], lcg[15:0]});
    end
    slot(0, 0, '0, '0);
    slot(0, 0, '0, '0);
    @(negedge clk);
    req_valid = 0;
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads answered", WW'(exp_q.size()), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule